// File: doc/BRIEF.md
# Commit-Window Error Flag Monitor

This block gathers the error flags of several pipelined arithmetic operators (divide-by-zero, domain error and similar) into one sticky error output for a microcoded sequential datapath. An operator's flag is taken into account only in a step where some destination register's write-select code picks that operator's output. That step is the operator's commit window. Outside that window the flag describes a result that nobody stores, so it is disregarded.

Besides the sticky flag, the block holds the executing step number (program counter) of the most recent qualifying error. Each accept of a new transaction clears both outputs. Errors never halt the machine: the transaction runs to completion and the host reads the flag and the step together with the result.

Top module: `cwerr_monitor`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `err` is 0 and `err_pc` is 0.
- R2: When `accept` is low, `transacting` is high, and for some operator k its bit `op_err[k]` is high while at least one register's write-select field equals k+1, then in the next cycle `err` is 1 and `err_pc` equals the `pc` of that cycle. The field of register r is `wr_sel[r*SEL_W +: SEL_W]`.
- R3: A raised `op_err[k]` has no effect on either output when no register's write-select field equals k+1. Select code 0 means "no write", and codes above N_OPS name non-operator sources.
- R4: While `transacting` is low and `accept` is low, neither output changes, whatever the flags and select fields are.
- R5: Once `err` is 1 it stays 1 through cycles that have no qualifying error, and `err_pc` stays unchanged, until the next accept.
- R6: A later qualifying error in the same transaction overwrites `err_pc` with the later step.
- R7: An accept clears `err` and `err_pc` to 0 in the next cycle, and this takes precedence over a qualifying error in the same cycle.
- R8: When several operators commit errors in one cycle, possibly through several registers, `err` is 1 and `err_pc` holds that single cycle's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | Strobe for a new transaction's inputs being taken; clears the outputs |
| transacting | input | 1 | High while the datapath executes a transaction |
| pc | input | PC_W | Step number currently executing |
| op_err | input | N_OPS | Error flag of each pooled operator, aligned to its result |
| wr_sel | input | N_REGS*SEL_W | Write-select code of each destination register, packed |
| err | output | 1 | Sticky error flag for the current transaction |
| err_pc | output | PC_W | Step of the most recent qualifying error |

## Verification
The bench uses three operators, four destination registers, a 3-bit select code and a 6-bit step counter. With these values every select code (none, each operator, and the non-operator codes 4 to 7) can be combined with every flag pattern on every register, with `transacting` at both levels, in a short run. That sweep separates qualified flags from disregarded ones. Directed sequences then cover stickiness, overwriting of the captured step, several errors committing in one cycle, and an accept that coincides with an error.

// File: rtl/cwerr_pkg.sv
package cwerr_pkg;

    // Class of a destination register's write-select code.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,   // register not written this step
        SRC_OPER  = 2'd1,   // register takes a pooled operator output
        SRC_OTHER = 2'd2    // register takes an inline / install source
    } src_kind_e;

    // Select code that routes pooled operator idx into a register.
    function automatic int unsigned oper_code(input int unsigned idx);
        return idx + 1;
    endfunction

    // Classify a select code given the number of pooled operators.
    function automatic src_kind_e src_kind(input int unsigned code,
                                           input int unsigned n_ops);
        if (code == 0)
            return SRC_NONE;
        else if (code <= n_ops)
            return SRC_OPER;
        else
            return SRC_OTHER;
    endfunction

endpackage

// File: rtl/cwerr_commit_decode.sv
module cwerr_commit_decode
    import cwerr_pkg::*;
#(
    parameter int N_OPS  = 3,
    parameter int N_REGS = 4,
    parameter int SEL_W  = 3
) (
    input  logic [N_REGS*SEL_W-1:0] wr_sel,
    output logic [N_OPS-1:0]        commit
);

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        logic sel_hit;
        always_comb begin
            sel_hit = 1'b0;
            for (int r = 0; r < N_REGS; r++) begin
                int unsigned code;
                code = int'(wr_sel[r*SEL_W +: SEL_W]);
                if (src_kind(code, N_OPS) == SRC_OPER &&
                    code == oper_code(g))
                    sel_hit = 1'b1;
            end
        end
        assign commit[g] = sel_hit;
    end

endmodule

// File: rtl/cwerr_qualify.sv
module cwerr_qualify #(
    parameter int N_OPS = 3
) (
    input  logic             transacting,
    input  logic [N_OPS-1:0] op_err,
    input  logic [N_OPS-1:0] commit,
    output logic             any_hit
);

    logic [N_OPS-1:0] windowed;

    assign windowed = op_err & commit;
    assign any_hit  = transacting & (|windowed);

endmodule

// File: rtl/cwerr_capture.sv
module cwerr_capture #(
    parameter int PC_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            any_hit,
    input  logic [PC_W-1:0] pc,
    output logic            err,
    output logic [PC_W-1:0] err_pc
);

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            err    <= 1'b0;
            err_pc <= '0;
        end else if (any_hit) begin
            err    <= 1'b1;
            err_pc <= pc;
        end
    end

endmodule

// File: rtl/cwerr_monitor.sv
module cwerr_monitor #(
    parameter int N_OPS  = 3,
    parameter int N_REGS = 4,
    parameter int SEL_W  = 3,
    parameter int PC_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  logic                    transacting,
    input  logic [PC_W-1:0]         pc,
    input  logic [N_OPS-1:0]        op_err,
    input  logic [N_REGS*SEL_W-1:0] wr_sel,
    output logic                    err,
    output logic [PC_W-1:0]         err_pc
);

    logic [N_OPS-1:0] commit;
    logic             any_hit;

    cwerr_commit_decode #(
        .N_OPS (N_OPS),
        .N_REGS(N_REGS),
        .SEL_W (SEL_W)
    ) u_decode (
        .wr_sel(wr_sel),
        .commit(commit)
    );

    cwerr_qualify #(
        .N_OPS(N_OPS)
    ) u_qualify (
        .transacting(transacting),
        .op_err     (op_err),
        .commit     (commit),
        .any_hit    (any_hit)
    );

    cwerr_capture #(
        .PC_W(PC_W)
    ) u_capture (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .any_hit(any_hit),
        .pc     (pc),
        .err    (err),
        .err_pc (err_pc)
    );

endmodule

// File: rtl/cwerr_monitor_chk.sv
module cwerr_monitor_chk #(
    parameter int N_OPS  = 3,
    parameter int N_REGS = 4,
    parameter int SEL_W  = 3,
    parameter int PC_W   = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    accept,
    input logic                    transacting,
    input logic [PC_W-1:0]         pc,
    input logic [N_OPS-1:0]        op_err,
    input logic [N_REGS*SEL_W-1:0] wr_sel,
    input logic                    err,
    input logic [PC_W-1:0]         err_pc
);

    // Independent view of "some flag sits in its commit window".
    logic win_hit;
    always_comb begin
        win_hit = 1'b0;
        for (int k = 0; k < N_OPS; k++)
            for (int r = 0; r < N_REGS; r++)
                if (op_err[k] && wr_sel[r*SEL_W +: SEL_W] == SEL_W'(k + 1))
                    win_hit = 1'b1;
        win_hit = win_hit & transacting;
    end

    assert_clear_on_accept_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!err && err_pc == '0));

    assert_capture_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!accept && win_hit) |=> (err && err_pc == $past(pc)));

    assert_outside_window_R3: assert property (@(posedge clk) disable iff (rst)
        (!accept && !win_hit) |=> ($stable(err) && $stable(err_pc)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!accept && !transacting) |=> ($stable(err) && $stable(err_pc)));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (err && !accept) |=> err);

endmodule

bind cwerr_monitor cwerr_monitor_chk #(
    .N_OPS (N_OPS),
    .N_REGS(N_REGS),
    .SEL_W (SEL_W),
    .PC_W  (PC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .transacting(transacting),
    .pc         (pc),
    .op_err     (op_err),
    .wr_sel     (wr_sel),
    .err        (err),
    .err_pc     (err_pc)
);

// File: tb/cwerr_monitor_tb.sv
module cwerr_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_OPS  = 3;
    localparam int N_REGS = 4;
    localparam int SEL_W  = 3;
    localparam int PC_W   = 6;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    accept = 1'b0;
    logic                    transacting = 1'b0;
    logic [PC_W-1:0]         pc = '0;
    logic [N_OPS-1:0]        op_err = '0;
    logic [N_REGS*SEL_W-1:0] wr_sel = '0;
    logic                    err;
    logic [PC_W-1:0]         err_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwerr_monitor #(
        .N_OPS(N_OPS), .N_REGS(N_REGS), .SEL_W(SEL_W), .PC_W(PC_W)
    ) u_dut (
        .clk(clk), .rst(rst), .accept(accept), .transacting(transacting),
        .pc(pc), .op_err(op_err), .wr_sel(wr_sel), .err(err), .err_pc(err_pc)
    );

    task automatic check(input string req, input logic exp_err,
                         input logic [PC_W-1:0] exp_pc);
        checks++;
        if (err !== exp_err || err_pc !== exp_pc) begin
            fails++;
            $display("FAIL %s: err=%0b err_pc=%0d expected err=%0b err_pc=%0d",
                     req, err, err_pc, exp_err, exp_pc);
        end
    endtask

    // Drive one step at a negedge; outputs are valid at the next negedge.
    task automatic step(input logic acc, input logic tr, input logic [PC_W-1:0] p,
                        input logic [N_OPS-1:0] f, input logic [N_REGS*SEL_W-1:0] s);
        accept = acc; transacting = tr; pc = p; op_err = f; wr_sel = s;
        @(negedge clk);
    endtask

    function automatic logic [N_REGS*SEL_W-1:0] one_sel(input int r, input int code);
        logic [N_REGS*SEL_W-1:0] v;
        v = '0;
        v[r*SEL_W +: SEL_W] = SEL_W'(code);
        return v;
    endfunction

    initial begin
        @(negedge clk);
        check("R1", 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 1'b0, '0);
        @(negedge clk);
        check("R1", 1'b0, '0);

        // Sweep: flag pattern x register x select code x transacting.
        for (int f = 0; f < (1 << N_OPS); f++) begin
            for (int r = 0; r < N_REGS; r++) begin
                for (int code = 0; code < (1 << SEL_W); code++) begin
                    for (int tr = 0; tr < 2; tr++) begin
                        logic [PC_W-1:0] p;
                        logic hit;
                        p = PC_W'((f * 5 + r * 3 + code * 7 + tr) % 63 + 1);
                        step(1'b1, 1'b0, '0, '0, '0);
                        check("R7", 1'b0, '0);
                        hit = (tr == 1) && (code >= 1) && (code <= N_OPS) &&
                              f[code-1];
                        step(1'b0, tr[0], p, N_OPS'(f), one_sel(r, code));
                        if (tr == 0)
                            check("R4", 1'b0, '0);
                        else if (hit)
                            check("R2", 1'b1, p);
                        else
                            check("R3", 1'b0, '0);
                    end
                end
            end
        end

        // Stickiness, overwrite and same-cycle cases.
        step(1'b1, 1'b0, '0, '0, '0);
        check("R7", 1'b0, '0);
        step(1'b0, 1'b1, 6'd10, 3'b010, one_sel(1, 2));
        check("R2", 1'b1, 6'd10);
        step(1'b0, 1'b1, 6'd11, 3'b111, one_sel(2, 5));
        check("R5", 1'b1, 6'd10);
        step(1'b0, 1'b1, 6'd12, 3'b000, one_sel(0, 1));
        check("R5", 1'b1, 6'd10);
        step(1'b0, 1'b0, 6'd13, 3'b001, one_sel(0, 1));
        check("R4", 1'b1, 6'd10);
        step(1'b0, 1'b1, 6'd20, 3'b001, one_sel(3, 1));
        check("R6", 1'b1, 6'd20);
        step(1'b0, 1'b1, 6'd33, 3'b111,
             one_sel(0, 1) | one_sel(1, 2) | one_sel(2, 3));
        check("R8", 1'b1, 6'd33);
        step(1'b0, 1'b1, 6'd40, 3'b101, one_sel(0, 3) | one_sel(3, 3));
        check("R8", 1'b1, 6'd40);
        step(1'b1, 1'b1, 6'd41, 3'b111, one_sel(0, 1));
        check("R7", 1'b0, '0);
        step(1'b0, 1'b1, 6'd42, 3'b000, '0);
        check("R5", 1'b0, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule